// File: doc/BRIEF.md
# Dual-Format Serial Audio Transmitter

The block sends stereo 24-bit two's complement samples, most significant bit first, over a three-wire serial port made of a bit clock, a word clock and a data line. The `fmt_i2s` input picks the framing. Low gives MSB-justified framing, where the word clock is high on the left channel. High gives I2S-style framing, where the word clock is low on the left channel and the MSB starts one bit later. The `slave_mode` input picks the clock role. As clock master, the block divides its own clock (the master clock, `clk`) to make a 64-bit-per-frame bit clock and a one-per-sample word clock. As clock slave, it oversamples an external bit clock and word clock in the `clk` domain and follows them.

A parallel stereo pair is offered through `in_valid`/`in_ready`. The block takes a pair only at the start of each left half-frame. If no pair is offered at that moment, the block sends the previous pair again and raises `underrun` for one clock. The data line only changes at a falling edge of the bit clock, which the block represents internally as a one-clock `tick`.

The sequencer has three states. TX_WAIT holds after reset with the data line low. It moves to TX_LEFT on the first tick in master mode. In slave mode it moves to TX_LEFT or TX_RIGHT on the first word-clock edge it detects. After that, TX_LEFT→TX_RIGHT and TX_RIGHT→TX_LEFT follow each half-frame boundary: every 32 bit clocks as master, and every detected word-clock edge as slave.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_n` is low, `sdata`, `bclk_out`, `wclk_out`, `in_ready` and `underrun` are all 0, and `fmt_i2s`=0 (MSB-justified) is the default framing.
- R2: As master, `bclk_out` has a period of MCLK_PER_FS/64 clocks (4 by default): low for the first half of each period and high for the second, counting from reset release. As slave, `bclk_out` and `wclk_out` stay low.
- R3: `sdata` changes only on a bit-clock falling edge. As master, this is the clock edge on which `bclk_out` falls. As slave, it is 3 clocks after the external falling edge reaches `bclk_in`.
- R4: With `fmt_i2s`=0, bit slot s (0-based from the half-frame start) carries sample bit 23-s for s=0..23, and the line is low in later slots. As master, `wclk_out` is 1 for the left half and 0 for the right half.
- R5: With `fmt_i2s`=1, slot 0 is low (except as in R6), slot s carries bit 24-s for s=1..24, and later slots are low. As master, `wclk_out` is 0 for the left half and 1 for the right half.
- R6: With `fmt_i2s`=1 in slave mode, if a half-frame ends after exactly 24 bit clocks, slot 0 of the next half carries the LSB of the word just sent.
- R7: As master, a frame is 64 bit clocks and each half-frame is 32. The first half-frame after reset is left, and `wclk_out` toggles every 32 bit clocks.
- R8: As slave, a half-frame starts at each falling bit-clock edge where the word-clock level differs from its level at the previous falling edge. The channel is left when (word clock XOR `fmt_i2s`) is 1. Before the first such edge, `sdata` is low and no pair is taken. Slots past 63 saturate and stay low.
- R9: `in_ready` is high for exactly one clock: the clock whose tick starts a left half-frame. A pair with `in_valid` high in that clock is latched, and its left word is sent in that half-frame.
- R10: If `in_valid` is low while `in_ready` is high, the previous pair is sent again and `underrun` is high for the following clock only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 0: block drives the serial clocks; 1: block follows `bclk_in`/`wclk_in` |
| fmt_i2s | input | 1 | 0: MSB-justified framing; 1: I2S-style framing |
| in_valid | input | 1 | A stereo pair is offered on `in_left`/`in_right` |
| in_ready | output | 1 | Pair is taken this clock (start of a left half-frame) |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave mode) |
| wclk_in | input | 1 | External word clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| wclk_out | output | 1 | Generated word clock (master mode) |
| sdata | output | 1 | Serial data, MSB first |
| underrun | output | 1 | One-clock pulse when a left half-frame starts without a new pair |

## Verification
The bench checks the I2S one-bit delay against the MSB-justified zero delay. A design that mixed them up would send every word shifted by one slot and lose the LSB or the MSB. It runs slave frames of exactly 24 bit clocks per half, in both framings. A design that padded blindly would drop the I2S LSB, and one that kept counting instead of restarting on the word-clock edge would send the wrong bits into the next half. It withholds `in_valid` at chosen left-half starts, which exposes a design that sends stale data without flagging it, or that flags the underrun but corrupts the repeated pair. Halves of 33 and 40 bit clocks check that data stops at slot 24 and the data line stays low until the next edge.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

    // Half-frame sequencer states
    typedef enum logic [1:0] {
        TX_WAIT  = 2'd0,
        TX_LEFT  = 2'd1,
        TX_RIGHT = 2'd2
    } tx_state_e;

endpackage

// File: rtl/aud_ser_clk.sv
module aud_ser_clk #(
    parameter int MCLK_PER_FS    = 256,
    parameter int BITS_PER_FRAME = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slave_mode,
    input  logic bclk_in,
    input  logic wclk_in,
    output logic tick,
    output logic bclk_out,
    output logic ws_edge,
    output logic ws_level
);

    localparam int DIV      = MCLK_PER_FS / BITS_PER_FRAME;
    localparam int HALF_DIV = DIV / 2;
    localparam int CW       = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_cnt;
    logic [2:0]    bsync;
    logic [1:0]    wsync;
    logic          ws_prev;
    logic          armed;
    logic          fall_seen;

    // Master divider: bclk_out rises mid-period and falls on the tick edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            bclk_out <= 1'b0;
        end else if (slave_mode) begin
            div_cnt  <= '0;
            bclk_out <= 1'b0;
        end else begin
            div_cnt <= (div_cnt == CNT_LAST) ? '0 : div_cnt + CW'(1);
            if (div_cnt == CNT_MID)
                bclk_out <= 1'b1;
            else if (div_cnt == CNT_LAST)
                bclk_out <= 1'b0;
        end
    end

    // Slave: oversample external clocks, detect falling bit-clock edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsync   <= '0;
            wsync   <= '0;
            ws_prev <= 1'b0;
            armed   <= 1'b0;
        end else begin
            bsync <= {bsync[1:0], bclk_in};
            wsync <= {wsync[0], wclk_in};
            if (slave_mode && fall_seen) begin
                ws_prev <= wsync[1];
                armed   <= 1'b1;
            end
        end
    end

    always_comb begin
        fall_seen = bsync[2] & ~bsync[1];
        tick      = slave_mode ? fall_seen : (div_cnt == CNT_LAST);
        ws_level  = wsync[1];
        ws_edge   = armed && (wsync[1] != ws_prev);
    end

    // R2: master tick coincides with the falling edge of bclk_out
    a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && tick) |=> !bclk_out);

    // R2: generated bit clock silent in slave mode
    a_r2_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && $past(slave_mode)) |-> !bclk_out);

endmodule

// File: rtl/aud_ser_frame.sv
module aud_ser_frame
    import aud_ser_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int HALF_SLOTS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slave_mode,
    input  logic                fmt_i2s,
    input  logic                tick,
    input  logic                ws_edge,
    input  logic                ws_level,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                in_ready,
    output logic                sdata,
    output logic                wclk_out,
    output logic                underrun
);

    localparam int SLOT_MAX = 2 * HALF_SLOTS - 1;
    localparam int SLW      = $clog2(SLOT_MAX + 1);
    localparam logic [SLW-1:0] SLOT_TOP = SLW'(SLOT_MAX);
    localparam logic [SLW-1:0] SLOT_END = SLW'(HALF_SLOTS - 1);
    localparam logic [SLW-1:0] SLOT_CUT = SLW'(SAMPLE_W - 1);
    localparam logic [SLW-1:0] SLOT_LEN = SLW'(SAMPLE_W);

    tx_state_e           state, state_nxt;
    logic [SLW-1:0]      slot, slot_nxt;
    logic [SAMPLE_W-1:0] held_l, held_r;
    logic                half_start, load, accept, cut, in_word;
    logic                bit_nxt, wclk_nxt;
    logic [SAMPLE_W-1:0] word_l, cur_word, prev_word, shifted;
    logic [SLW-1:0]      data_slot;

    // Next-state logic
    always_comb begin
        half_start = slave_mode ? ws_edge
                                : ((state == TX_WAIT) || (slot == SLOT_END));
        state_nxt  = state;
        if (tick && half_start) begin
            if (slave_mode) begin
                state_nxt = (ws_level ^ fmt_i2s) ? TX_LEFT : TX_RIGHT;
            end else begin
                unique case (state)
                    TX_WAIT:  state_nxt = TX_LEFT;
                    TX_LEFT:  state_nxt = TX_RIGHT;
                    TX_RIGHT: state_nxt = TX_LEFT;
                    default:  state_nxt = TX_LEFT;
                endcase
            end
        end
        if (!tick)
            slot_nxt = slot;
        else if (half_start)
            slot_nxt = '0;
        else
            slot_nxt = (slot == SLOT_TOP) ? slot : slot + SLW'(1);
    end

    // Sample selection and bit steering
    always_comb begin
        load      = tick && half_start && (state_nxt == TX_LEFT);
        accept    = load && in_valid;
        word_l    = accept ? in_left : held_l;
        cur_word  = (state_nxt == TX_LEFT) ? word_l : held_r;
        prev_word = (state == TX_LEFT) ? held_l : held_r;
        cut       = fmt_i2s && half_start && (state != TX_WAIT) && (slot == SLOT_CUT);
        data_slot = fmt_i2s ? slot_nxt - SLW'(1) : slot_nxt;
        in_word   = fmt_i2s ? ((slot_nxt != '0) && (slot_nxt <= SLOT_LEN))
                            : (slot_nxt < SLOT_LEN);
        shifted   = cur_word << data_slot;
        if (state_nxt == TX_WAIT)
            bit_nxt = 1'b0;
        else if (cut)
            bit_nxt = prev_word[0];
        else
            bit_nxt = in_word ? shifted[SAMPLE_W-1] : 1'b0;
        if (slave_mode || state_nxt == TX_WAIT)
            wclk_nxt = 1'b0;
        else
            wclk_nxt = (state_nxt == TX_LEFT) ^ fmt_i2s;
    end

    assign in_ready = load;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_WAIT;
            slot  <= SLOT_END;
        end else begin
            state <= state_nxt;
            slot  <= slot_nxt;
        end
    end

    // Output and sample registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata    <= 1'b0;
            wclk_out <= 1'b0;
            underrun <= 1'b0;
            held_l   <= '0;
            held_r   <= '0;
        end else begin
            underrun <= load && !in_valid;
            if (tick) begin
                sdata    <= bit_nxt;
                wclk_out <= wclk_nxt;
            end
            if (accept) begin
                held_l <= in_left;
                held_r <= in_right;
            end
        end
    end

    // R3: data only moves on a bit-clock falling edge
    a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sdata));

    // R9: a take always opens a left half-frame at slot 0
    a_r9_ready_opens_left: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (state == TX_LEFT) && (slot == '0));

    // R10: underrun only follows a take with nothing offered
    a_r10_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(in_ready && !in_valid));

    // R4, R5: padding slots stay low
    a_r4_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != TX_WAIT) && (slot > SLOT_LEN)) |-> !sdata);

    // R8: nothing is sent before the first half-frame
    a_r8_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_WAIT) |-> (!sdata && !wclk_out));

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
    parameter int SAMPLE_W    = 24,
    parameter int MCLK_PER_FS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slave_mode,
    input  logic                fmt_i2s,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                bclk_in,
    input  logic                wclk_in,
    output logic                bclk_out,
    output logic                wclk_out,
    output logic                sdata,
    output logic                underrun
);

    localparam int HALF_SLOTS     = 32;
    localparam int BITS_PER_FRAME = 2 * HALF_SLOTS;

    logic tick, ws_edge, ws_level;

    aud_ser_clk #(
        .MCLK_PER_FS   (MCLK_PER_FS),
        .BITS_PER_FRAME(BITS_PER_FRAME)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .slave_mode(slave_mode),
        .bclk_in   (bclk_in),
        .wclk_in   (wclk_in),
        .tick      (tick),
        .bclk_out  (bclk_out),
        .ws_edge   (ws_edge),
        .ws_level  (ws_level)
    );

    aud_ser_frame #(
        .SAMPLE_W  (SAMPLE_W),
        .HALF_SLOTS(HALF_SLOTS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .slave_mode(slave_mode),
        .fmt_i2s   (fmt_i2s),
        .tick      (tick),
        .ws_edge   (ws_edge),
        .ws_level  (ws_level),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .in_ready  (in_ready),
        .sdata     (sdata),
        .wclk_out  (wclk_out),
        .underrun  (underrun)
    );

endmodule

// File: tb/tb_aud_ser_tx.sv
`timescale 1ns/1ps
module tb_aud_ser_tx;

    localparam int SW  = 24;
    localparam int MPF = 256;
    localparam int DIV = MPF / 64;
    localparam int SP  = 8;   // slave bit period in clk cycles

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, slave_mode, fmt_i2s, in_valid, in_ready;
    logic [SW-1:0] in_left, in_right;
    logic bclk_in, wclk_in, bclk_out, wclk_out, sdata, underrun;

    aud_ser_tx #(.SAMPLE_W(SW), .MCLK_PER_FS(MPF)) dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .fmt_i2s(fmt_i2s),
        .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
        .bclk_in(bclk_in), .wclk_in(wclk_in), .bclk_out(bclk_out), .wclk_out(wclk_out),
        .sdata(sdata), .underrun(underrun)
    );

    int vec = 0;
    int bad = 0;
    int n;
    // reference model state
    int m_state, m_slot, loads;
    logic [SW-1:0] h_l, h_r;
    logic e_sdata, e_wclk, e_bclk, e_under;
    string e_tag;
    int tq_t[$];
    int tq_k[$];
    // slave stimulus generator
    int g_cnt, g_bit, g_half, g_H, g_nh;
    bit g_done;

    task automatic chk(string tag, string what, logic act, logic exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, what, n, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] gen_word(int i, bit right);
        logic [SW-1:0] w;
        case (i % 4)
            0:       w = 24'h800000;
            1:       w = 24'h000001;
            2:       w = 24'hC3A5F1 ^ 24'(i);
            default: w = 24'h7FFFFF;
        endcase
        if (right) w = {w[0], w[SW-1:1]} ^ 24'h5A5A5A;
        return w;
    endfunction

    // kind of tick at posedge t: -1 none, 0 continue, 1 left start, 2 right start
    function automatic int kind_at(int t);
        int k, p;
        if (!slave_mode) begin
            if (t == 0 || (t % DIV) != 0) return -1;
            k = t / DIV;
            p = (k - 1) % 64;
            if (p % 32 != 0) return 0;
            return (p < 32) ? 1 : 2;
        end
        if (tq_t.size() > 0 && tq_t[0] == t) return tq_k[0];
        return -1;
    endfunction

    task automatic slave_drive();
        int kd;
        bit left;
        if (!slave_mode || g_done) return;
        if (g_cnt == 0) begin
            if (g_half > g_nh) begin
                g_done = 1'b1;
                return;
            end
            bclk_in = 1'b0;
            kd = 0;
            if (g_bit == 0 && g_half > 0) begin
                left    = (g_half % 2) == 1;
                wclk_in = left ? ~fmt_i2s : fmt_i2s;
                kd      = left ? 1 : 2;
            end
            tq_t.push_back(n + 3);
            tq_k.push_back(kd);
            g_bit++;
            if (g_bit == ((g_half == 0) ? 3 : g_H)) begin
                g_bit = 0;
                g_half++;
            end
        end else if (g_cnt == SP / 2) begin
            bclk_in = 1'b1;
        end
        g_cnt = (g_cnt + 1) % SP;
    endtask

    task automatic advance();
        int t, kd, ps, pslot, ds;
        logic [SW-1:0] pw, cw;
        bit cut;
        t = n + 1;
        kd = kind_at(t);
        e_under = 1'b0;
        e_bclk  = !slave_mode ? ((t % DIV) >= DIV / 2) : 1'b0;
        if (kd >= 0) begin
            if (slave_mode) begin
                void'(tq_t.pop_front());
                void'(tq_k.pop_front());
            end
            ps = m_state; pslot = m_slot;
            pw = (m_state == 1) ? h_l : h_r;
            if (kd == 0) m_slot = (m_slot < 63) ? m_slot + 1 : 63;
            else begin m_slot = 0; m_state = kd; end
            if (kd == 1) begin
                if (in_valid) begin
                    h_l = gen_word(loads, 0);
                    h_r = gen_word(loads, 1);
                end else e_under = 1'b1;
                loads++;
            end
            cut = fmt_i2s && kd != 0 && ps != 0 && pslot == 23;
            e_tag = slave_mode ? "R3 R8" : (fmt_i2s ? "R3 R5" : "R3 R4");
            if (m_state == 0) e_sdata = 1'b0;
            else if (cut) begin
                e_sdata = pw[0];
                e_tag = "R6";
            end else begin
                ds = fmt_i2s ? m_slot - 1 : m_slot;
                cw = (m_state == 1) ? h_l : h_r;
                e_sdata = (ds >= 0 && ds < SW) ? cw[SW-1-ds] : 1'b0;
            end
            e_wclk = (!slave_mode && m_state != 0) ? ((m_state == 1) ^ fmt_i2s) : 1'b0;
        end
        n = t;
    endtask

    task automatic do_reset(bit slv, bit fmt, int half_len, int halves);
        rst_n = 1'b0; slave_mode = slv; fmt_i2s = fmt;
        bclk_in = 1'b1; wclk_in = fmt; in_valid = 1'b0;
        in_left = '0; in_right = '0;
        repeat (3) @(negedge clk);
        n = 0;
        chk("R1", "sdata", sdata, 1'b0);
        chk("R1", "bclk_out", bclk_out, 1'b0);
        chk("R1", "wclk_out", wclk_out, 1'b0);
        chk("R1", "in_ready", in_ready, 1'b0);
        chk("R1", "underrun", underrun, 1'b0);
        m_state = 0; m_slot = 31; loads = 0; h_l = '0; h_r = '0;
        e_sdata = 0; e_wclk = 0; e_bclk = 0; e_under = 0; e_tag = "R3";
        tq_t.delete(); tq_k.delete();
        g_cnt = SP / 2; g_bit = 0; g_half = 0; g_H = half_len; g_nh = halves; g_done = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic run(int cycles);
        for (int c = 0; c < cycles; c++) begin
            in_left  = gen_word(loads, 0);
            in_right = gen_word(loads, 1);
            in_valid = (loads % 5) != 3;
            slave_drive();
            chk("R9", "in_ready", in_ready, kind_at(n + 1) == 1);
            advance();
            @(negedge clk);
            chk(e_tag, "sdata", sdata, e_sdata);
            chk(slave_mode ? "R2" : "R7", "wclk_out", wclk_out, e_wclk);
            chk("R2", "bclk_out", bclk_out, e_bclk);
            chk("R10", "underrun", underrun, e_under);
        end
    endtask

    initial begin
        // master, MSB-justified (R4, R7), five frames
        do_reset(0, 0, 0, 0);  run(5 * 64 * DIV + 8);
        // master, I2S (R5)
        do_reset(0, 1, 0, 0);  run(5 * 64 * DIV + 8);
        // slave, 48 bit clocks per frame, both framings (R8, R6)
        do_reset(1, 0, 24, 8); run(SP * (3 + 24 * 8) + 2 * SP);
        do_reset(1, 1, 24, 8); run(SP * (3 + 24 * 8) + 2 * SP);
        // slave, longer halves: padding and slot saturation (R8)
        do_reset(1, 1, 40, 6); run(SP * (3 + 40 * 6) + 2 * SP);
        do_reset(1, 0, 33, 6); run(SP * (3 + 33 * 6) + 2 * SP);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule